// File: doc/BRIEF.md
# Prioritised 32-Line Interrupt Controller

This block gathers up to 32 external interrupt lines into two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own configuration word. The word sets a 5-bit priority, chooses the detection style (sense on the asserting edge, or sense while the line is held), and picks which of the two requests the line feeds. The request inputs are active high and mean "line asserted". Each input passes through a two-flop synchroniser before any detection is done.

Software reaches the block through a simple 32-bit word-addressed register port, with one-cycle registered read data. Software can read and clear the pending bits and mask individual lines. It can read the code of the winning line for each request path. Reading that code acknowledges an edge-sensed line. Software can also raise a line itself and re-arm either path after servicing. When a path is armed and has an unmasked pending line, the block latches the winner's code and raises the path's output. The output and the code stay put until that path is acknowledged.

Top module: `line_intc`

## Requirements
- R1: After reset the pending bits and all configuration words read 0, the mask (word address 0x04) reads all ones, both active codes read 0, and both request outputs are low.
- R2: Each request input passes through two synchroniser flops. A 0-to-1 change of the synchronised input on an edge-sensed line (sense bit 0) sets that line's pending bit on the third rising clock edge after the input change. The bit stays set after the input drops.
- R3: On a level-sensed line (sense bit 1), the pending bit is set for as long as the synchronised input is high. It clears when the synchronised input falls.
- R4: Offset 0x00 reads the pending bits (bit n = line n). Writing it ANDs the pending bits with the write data, except that a level-sensed line whose input is still high keeps its bit.
- R5: Offset 0x04 holds the mask, where bit n = 1 blocks line n from arbitration. A write takes effect for both request paths.
- R6: The configuration word of line n is at 0x1C + 4n. Its fields are priority in bits [6:2], sense in bit 1 and route in bit 0 (0 = normal path, 1 = fast path). It reads back in the same layout with the upper bits 0.
- R7: An armed path with at least one unmasked pending line routed to it picks the line with the numerically smallest priority; on a tie the highest-numbered line wins. The path then latches that line's number as its active code, raises its output, and holds both until it is acknowledged.
- R8: A read of 0x10 returns the normal-path code and a read of 0x14 returns the fast-path code. Such a read clears the pending bit of the reported line when that line is edge-sensed and leaves a level-sensed line untouched. Writes to these offsets have no effect.
- R9: Writing 0x18 with bit 0 set acknowledges the normal path, and writing it with bit 1 set acknowledges the fast path. An acknowledge drops that path's output on the next edge and re-arms it. Offset 0x18 reads 0.
- R10: A write to 0x9C sets the pending bit of only the lowest-numbered line whose data bit is 1. Offset 0x9C reads 0.
- R11: Reads of offsets outside the map (for example 0x08, 0x0C, 0xA0) return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NLINES | Interrupt line inputs, 1 = asserted (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq_o | output | 1 | Normal-path interrupt request |
| fiq_o | output | 1 | Fast-path interrupt request |

## Verification
The bench drives a full sweep in which every line is raised at once under a permuted set of priorities, then serviced one at a time. If a design compared priorities the wrong way round, or dropped the "last equal wins" tie rule, it would report lines in the wrong order; a separate two-line tie case isolates the tie rule. The two detection styles are checked against each other:
- A level line must survive both a clear-by-write and a code read.
- An edge line must not re-trigger while its input is held high.

A design that let the code read clear a level line, or that treated a held edge line as a fresh event, would fail these checks. The synchroniser latency is measured to the exact edge, and a software trigger with two bits set must raise only the lower line.

// File: rtl/line_intc.sv
module line_intc #(
  parameter int NLINES = 32,
  parameter int PRI_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W  = $clog2(NLINES);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CFG_W  = PRI_W + 2;
  localparam logic [WORD_W-1:0] W_PEND  = 0;
  localparam logic [WORD_W-1:0] W_MASK  = 1;
  localparam logic [WORD_W-1:0] W_ICODE = 4;
  localparam logic [WORD_W-1:0] W_FCODE = 5;
  localparam logic [WORD_W-1:0] W_ACK   = 6;
  localparam int CFG0 = 7;
  localparam logic [WORD_W-1:0] W_SWT   = WORD_W'(CFG0 + NLINES);

  logic [NLINES-1:0] sync1_q, req_q, in_q, pend_q, mask_q, sense_q, route_q;
  logic [PRI_W-1:0]  pri_q [NLINES];
  logic [1:0]        arm_q, out_q, win_hit, ack;
  logic [IDX_W-1:0]  code_q [2];
  logic [IDX_W-1:0]  win_idx [2];
  logic [NLINES-1:0] set_v, clr_v, wr_clr, rd_clr, swt_v, wlow, pend_d;

  wire [WORD_W-1:0] word   = addr_i[ADDR_W-1:2];
  wire [WORD_W-1:0] cfg_off = word - WORD_W'(CFG0);
  wire              cfg_hit = (word >= WORD_W'(CFG0)) && (word < W_SWT);
  wire [IDX_W-1:0]  cfg_idx = cfg_off[IDX_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], cfg_off};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      req_q   <= '0;
      in_q    <= '0;
    end else begin
      sync1_q <= req_i;
      req_q   <= sync1_q;
      in_q    <= req_q;
    end

  assign wlow   = wdata_i[NLINES-1:0];
  assign swt_v  = (wr_en && word == W_SWT) ? (wlow & (~wlow + 1'b1)) : '0;
  assign wr_clr = (wr_en && word == W_PEND) ? ~(wlow | (sense_q & req_q)) : '0;
  assign ack    = (wr_en && word == W_ACK) ? wdata_i[1:0] : 2'b00;

  always_comb begin
    rd_clr = '0;
    if (rd_en && word == W_ICODE) rd_clr[code_q[0]] = ~sense_q[code_q[0]];
    if (rd_en && word == W_FCODE) rd_clr[code_q[1]] = ~sense_q[code_q[1]];
  end

  assign set_v  = (~sense_q & req_q & ~in_q) | (sense_q & req_q) | swt_v;
  assign clr_v  = (sense_q & in_q & ~req_q) | wr_clr | rd_clr;
  assign pend_d = (pend_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_d;
      if (wr_en && word == W_MASK) mask_q <= wlow;
    end

  for (genvar n = 0; n < NLINES; n++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pri_q[n]   <= '0;
        sense_q[n] <= 1'b0;
        route_q[n] <= 1'b0;
      end else if (wr_en && cfg_hit && cfg_idx == IDX_W'(n)) begin
        pri_q[n]   <= wdata_i[PRI_W+1:2];
        sense_q[n] <= wdata_i[1];
        route_q[n] <= wdata_i[0];
      end
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic [NLINES-1:0] cand;
    logic [PRI_W-1:0]  best;
    assign cand = pend_q & ~mask_q & (p == 1 ? route_q : ~route_q);

    always_comb begin
      win_hit[p] = 1'b0;
      win_idx[p] = '0;
      best       = '1;
      for (int i = 0; i < NLINES; i++)
        if (cand[i] && (!win_hit[p] || pri_q[i] <= best)) begin
          win_hit[p] = 1'b1;
          win_idx[p] = IDX_W'(i);
          best       = pri_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        arm_q[p]  <= 1'b1;
        out_q[p]  <= 1'b0;
        code_q[p] <= '0;
      end else if (ack[p]) begin
        arm_q[p] <= 1'b1;
        out_q[p] <= 1'b0;
      end else if (arm_q[p] && win_hit[p]) begin
        arm_q[p]  <= 1'b0;
        out_q[p]  <= 1'b1;
        code_q[p] <= win_idx[p];
      end
  end

  assign irq_o = out_q[0];
  assign fiq_o = out_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata_o <= '0;
    else if (rd_en) begin
      rdata_o <= '0;
      if (word == W_PEND)       rdata_o <= DATA_W'(pend_q);
      else if (word == W_MASK)  rdata_o <= DATA_W'(mask_q);
      else if (word == W_ICODE) rdata_o <= DATA_W'(code_q[0]);
      else if (word == W_FCODE) rdata_o <= DATA_W'(code_q[1]);
      else if (cfg_hit)
        rdata_o <= DATA_W'({pri_q[cfg_idx], sense_q[cfg_idx], route_q[cfg_idx]});
    end

  logic unused_w;
  assign unused_w = ^{CFG_W[0]};
endmodule

module line_intc_chk #(
  parameter int NLINES = 32,
  parameter int IDX_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [NLINES-1:0] pend,
  input logic [NLINES-1:0] mask,
  input logic [NLINES-1:0] route,
  input logic [IDX_W-1:0]  code_irq,
  input logic [IDX_W-1:0]  code_fiq
);
  wire [ADDR_W-3:0] word = addr_i[ADDR_W-1:2];

  assert_irq_needs_cand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(pend & ~mask & ~route)));
  assert_fiq_needs_cand_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(|(pend & ~mask & route)));
  assert_irq_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (!irq_o || $stable(code_irq)));
  assert_fiq_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |=> (!fiq_o || $stable(code_fiq)));
  assert_ack_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 6 && wdata_i[0]) |=> !irq_o);
  assert_ack_fiq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 6 && wdata_i[1]) |=> !fiq_o);
  assert_ack_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == 6) |=> rdata_o == '0);
  assert_swt_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word == 6'(7 + NLINES)) |=> rdata_o == '0);
  assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (word == 2 || word == 3)) |=> rdata_o == '0);
endmodule

bind line_intc line_intc_chk #(.NLINES(NLINES), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .pend(pend_q), .mask(mask_q), .route(route_q),
  .code_irq(code_q[0]), .code_fiq(code_q[1]));

// File: tb/line_intc_tb.sv
module line_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          checks = 0, fails = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  line_intc u_dut (.clk(clk), .rst_n(rst_n), .req_i(req), .wr_en(wr_en), .rd_en(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  function automatic logic [6:0] cfg_pat(input int n);
    return 7'(((n * 11 + 3) % 32) << 2) | 7'((n % 3 == 0) << 1) | 7'(n % 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] left;
    int exp_idx, best;
    idle(1);
    do_reset();

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq}, 0);
    chk("R1 fiq_o", {31'b0, fiq}, 0);
    rd(8'h00, v); chk("R1 pending", v, 0);
    rd(8'h04, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R1 fast code", v, 0);
    rd(8'h10, v); chk("R1 normal code", v, 0);
    for (int n = 0; n < 32; n++) begin
      rd(8'(8'h1C + 4 * n), v); chk("R1 config", v, 0);
    end

    // R6 config layout sweep with junk in upper bits
    for (int n = 0; n < 32; n++) wr(8'(8'h1C + 4 * n), 32'hFFFF_FF80 | 32'(cfg_pat(n)));
    for (int n = 0; n < 32; n++) begin
      rd(8'(8'h1C + 4 * n), v); chk("R6 config readback", v, 32'(cfg_pat(n)));
    end

    // R12-style latency of synchroniser (R2)
    do_reset();
    req[20] = 1'b1;
    idle(2);
    rd(8'h00, v); chk("R2 sync latency not yet", v, 0);
    rd(8'h00, v); chk("R2 sync latency set", v, 32'h0010_0000);

    // R2 edge line behaviour
    do_reset();
    req[3] = 1'b1; idle(5);
    rd(8'h00, v); chk("R2 edge set", v, 32'h8);
    wr(8'h00, ~32'h8); idle(4);
    rd(8'h00, v); chk("R4 edge cleared while held", v, 0);
    req[3] = 1'b0; idle(4);
    rd(8'h00, v); chk("R2 no set on fall", v, 0);
    req[3] = 1'b1; idle(4); req[3] = 1'b0; idle(4);
    rd(8'h00, v); chk("R2 edge stays after drop", v, 32'h8);

    // R3/R4 level line
    wr(8'h30, 32'h2);
    req[5] = 1'b1; idle(5);
    rd(8'h00, v); chk("R3 level set", v, 32'h28);
    wr(8'h00, 32'h0); idle(1);
    rd(8'h00, v); chk("R4 level held survives clear", v, 32'h20);
    req[5] = 1'b0; idle(4);
    rd(8'h00, v); chk("R3 level clears on drop", v, 0);

    // R10 software trigger, R7 tie rule
    do_reset();
    wr(8'h24, 32'h10); wr(8'h40, 32'h10);
    wr(8'h9C, 32'h204); idle(1);
    rd(8'h00, v); chk("R10 only lowest line", v, 32'h4);
    wr(8'h9C, 32'h200);
    rd(8'h00, v); chk("R10 second trigger", v, 32'h204);
    idle(3); chk("R5 masked no irq", {31'b0, irq}, 0);
    wr(8'h04, 32'h0); idle(3);
    chk("R5 unmask raises irq", {31'b0, irq}, 1);
    rd(8'h10, v); chk("R7 tie highest line", v, 9);
    rd(8'h00, v); chk("R8 edge cleared by code read", v, 32'h4);
    wr(8'h18, 32'h1);
    chk("R9 ack drops irq", {31'b0, irq}, 0);
    idle(2); rd(8'h10, v); chk("R7 next winner", v, 2);

    // R7 full arbitration sweep
    do_reset();
    for (int n = 0; n < 32; n++) wr(8'(8'h1C + 4 * n), 32'(((n * 13 + 5) % 32) << 2));
    for (int n = 0; n < 32; n++) wr(8'h9C, 32'(1) << n);
    rd(8'h00, v); chk("R10 all triggered", v, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    left = 32'hFFFF_FFFF;
    for (int k = 0; k < 32; k++) begin
      exp_idx = 0; best = 99;
      for (int i = 0; i < 32; i++)
        if (left[i] && ((i * 13 + 5) % 32) <= best) begin
          best = (i * 13 + 5) % 32; exp_idx = i;
        end
      idle(3);
      chk("R7 sweep irq high", {31'b0, irq}, 1);
      rd(8'h10, v); chk("R7 sweep winner", v, 32'(exp_idx));
      left[exp_idx] = 1'b0;
      wr(8'h18, 32'h1);
    end
    idle(3);
    chk("R7 sweep done irq low", {31'b0, irq}, 0);
    rd(8'h00, v); chk("R8 sweep all cleared", v, 0);

    // Fast path, R9 ack selectivity
    do_reset();
    wr(8'h38, 32'h1); wr(8'h04, 32'h0);
    wr(8'h9C, 32'h80); idle(3);
    chk("R7 fast raised", {31'b0, fiq}, 1);
    chk("R7 normal quiet", {31'b0, irq}, 0);
    wr(8'h18, 32'h1); idle(1);
    chk("R9 normal ack keeps fast", {31'b0, fiq}, 1);
    rd(8'h14, v); chk("R8 fast code", v, 7);
    wr(8'h18, 32'h2);
    chk("R9 fast ack drops", {31'b0, fiq}, 0);
    idle(2); chk("R9 fast stays low", {31'b0, fiq}, 0);

    // R8 level line not cleared by code read
    do_reset();
    wr(8'h4C, 32'h2); wr(8'h04, ~32'h1000);
    req[12] = 1'b1; idle(6);
    chk("R3 level raises irq", {31'b0, irq}, 1);
    rd(8'h10, v); chk("R8 level code", v, 12);
    rd(8'h00, v); chk("R8 level kept after read", v, 32'h1000);
    req[12] = 1'b0; idle(4);
    rd(8'h00, v); chk("R3 level drop clears", v, 0);

    // R11 holes and read-only offsets
    do_reset();
    wr(8'h9C, 32'h2);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'hA0, 32'hFFFF_FFFF); wr(8'h10, 32'h1F); wr(8'h14, 32'h1F);
    rd(8'h08, v); chk("R11 hole 08", v, 0);
    rd(8'h0C, v); chk("R11 hole 0C", v, 0);
    rd(8'hA0, v); chk("R11 hole A0", v, 0);
    rd(8'h18, v); chk("R9 ack reads zero", v, 0);
    rd(8'h9C, v); chk("R10 trigger reads zero", v, 0);
    rd(8'h00, v); chk("R11 pending unchanged", v, 32'h2);
    rd(8'h04, v); chk("R11 mask unchanged", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R8 code write ignored", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule